// File: doc/BRIEF.md
# Two-Phase Registered 4-Bit ALU

A small two's-complement arithmetic logic unit for a narrow datapath. Each calculation takes two strobes of one system clock. In the first strobe, phase A, the block captures the operands `a_i` and `acc_i`. In a later strobe, phase B, the block takes the operation code of that cycle, computes a result from the captured operands and registers it on `result_o`. The two strobes stand in for two non-overlapping clock phases, so the operand inputs may change freely between them.

The block has three sub-units that share one control bit, bit 0 of the operation code. The logic unit picks AND or OR with it. The adder picks add or subtract with it: subtraction inverts the A operand and feeds the same bit in as carry-in. The rotator picks left or right with it. Bit 1 chooses between the logic result and the arithmetic result, and bit 2 chooses the rotator over both. Every result wraps modulo 16, and no carry or overflow is reported.

Top module: `alu4_two_phase`

## Requirements
- R1: While `rst_ni` is low, both operand registers and the result register are zero, so `result_o` reads 0.
- R2: The operands are captured only at a clock edge where `ph_a_i` is high. In every other cycle the captured values hold, whatever `a_i` and `acc_i` do.
- R3: `result_o` changes only at a clock edge where `ph_b_i` is high. It is computed from the captured operands and the `op_i` of that same cycle. In every other cycle `result_o` holds.
- R4: Code 3'b010 gives (ACC + A) mod 16.
- R5: Code 3'b011 gives (ACC − A) mod 16.
- R6: Code 3'b001 gives ACC AND A, and code 3'b000 gives ACC OR A.
- R7: Codes 3'b100 and 3'b110 rotate ACC left by one bit: {acc[2:0], acc[3]}.
- R8: Codes 3'b101 and 3'b111 rotate ACC right by one bit: {acc[0], acc[3:1]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ph_a_i | input | 1 | Operand capture strobe (phase A) |
| ph_b_i | input | 1 | Result capture strobe (phase B) |
| op_i | input | 3 | Operation code, sampled when `ph_b_i` is high |
| a_i | input | 4 | A operand |
| acc_i | input | 4 | Accumulator operand |
| result_o | output | 4 | Registered result |

## Verification
The assertions assume that `ph_a_i` and `ph_b_i` are never high in the same cycle, as two non-overlapping phases would be. One assertion checks exactly this assumption. The stimulus always pairs a phase-A cycle with a later phase-B cycle and never raises both strobes together. In phase-B cycles, and in idle cycles placed between the two phases, the bench drives unrelated values on the operand inputs. This shows that only the captured operands reach the result.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned OP_W   = 3;

  // bit0: sub-function, bit1: arith vs logic, bit2: rotator
  typedef enum logic [OP_W-1:0] {
    OP_OR  = 3'b000,
    OP_AND = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b011,
    OP_ROL = 3'b100,
    OP_ROR = 3'b101
  } alu_op_e;
endpackage

// File: rtl/alu4_logic.sv
module alu4_logic #(
  parameter int unsigned W = 4
) (
  input  logic         and_sel_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] z_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign z_o[g] = and_sel_i ? (x_i[g] & y_i[g]) : (x_i[g] | y_i[g]);
  end

  // a set result bit always needs at least one set operand bit
  always_comb begin
    assert_logic_subset_R6: assert ((z_o & ~(x_i | y_i)) == '0);
  end
endmodule

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
  parameter int unsigned W = 4
) (
  input  logic         sub_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] a_x;
  logic [W-1:0] cin;

  assign a_x   = a_i ^ {W{sub_i}};
  assign cin   = {{(W-1){1'b0}}, sub_i};
  assign sum_o = acc_i + a_x + cin;  // carry-out dropped

  always_comb begin
    if (sub_i && (a_i == acc_i)) begin
      assert_sub_self_R5: assert (sum_o == '0);
    end
  end
endmodule

// File: rtl/alu4_rotate.sv
module alu4_rotate #(
  parameter int unsigned W = 4
) (
  input  logic         right_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] rol;
  logic [W-1:0] ror;

  assign rol = {d_i[W-2:0], d_i[W-1]};
  assign ror = {d_i[0], d_i[W-1:1]};
  assign q_o = right_i ? ror : rol;

  always_comb begin
    assert_rot_keeps_bits_R7: assert ($countones(q_o) == $countones(d_i));
  end
endmodule

// File: rtl/alu4_two_phase.sv
module alu4_two_phase
  import alu4_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ph_a_i,
  input  logic              ph_b_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] a_q, acc_q, res_q;
  logic [DATA_W-1:0] logic_res, arith_res, rot_res, first_res, res_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      acc_q <= '0;
    end else if (ph_a_i) begin
      a_q   <= a_i;
      acc_q <= acc_i;
    end
  end

  alu4_logic #(.W(DATA_W)) i_logic (
    .and_sel_i (op_i[0]),
    .x_i       (acc_q),
    .y_i       (a_q),
    .z_o       (logic_res)
  );

  alu4_addsub #(.W(DATA_W)) i_addsub (
    .sub_i (op_i[0]),
    .acc_i (acc_q),
    .a_i   (a_q),
    .sum_o (arith_res)
  );

  alu4_rotate #(.W(DATA_W)) i_rotate (
    .right_i (op_i[0]),
    .d_i     (acc_q),
    .q_o     (rot_res)
  );

  assign first_res = op_i[1] ? arith_res : logic_res;
  assign res_d     = op_i[2] ? rot_res : first_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (ph_b_i) res_q <= res_d;
  end

  assign result_o = res_q;

  assert_phase_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph_a_i && ph_b_i));

  assert_res_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_b_i |=> $stable(result_o));

  assert_opnd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_a_i |=> ($stable(a_q) && $stable(acc_q)));

  assert_rot_popcount_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_b_i && op_i[2]) |=> ($countones(result_o) == $countones($past(acc_q))));
endmodule

// File: tb/test_alu4_two_phase.sv
module test_alu4_two_phase;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ph_a_i = 1'b0;
  logic       ph_b_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [3:0] a_i = '0;
  logic [3:0] acc_i = '0;
  logic [3:0] result_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  int    m_a = 0, m_acc = 0, m_res = 0;
  string cur_req = "R1";
  bit    force_r2 = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  alu4_two_phase i_alu4_two_phase (
    .clk_i, .rst_ni, .ph_a_i, .ph_b_i, .op_i, .a_i, .acc_i, .result_o
  );

  function automatic int ref_op(int op, int a, int acc);
    case (op)
      0:       return (acc | a) & 15;
      1:       return acc & a;
      2:       return (acc + a) & 15;
      3:       return (acc - a) & 15;
      4, 6:    return ((acc << 1) | (acc >> 3)) & 15;
      default: return ((acc >> 1) | ((acc & 1) << 3)) & 15;
    endcase
  endfunction

  function automatic string req_of(int op);
    case (op)
      0, 1:    return "R6";
      2:       return "R4";
      3:       return "R5";
      4, 6:    return "R7";
      default: return "R8";
    endcase
  endfunction

  // reference model, one update per clock
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_a <= 0; m_acc <= 0; m_res <= 0; cur_req <= "R1";
    end else begin
      if (ph_a_i) begin m_a <= int'(a_i); m_acc <= int'(acc_i); end
      if (ph_b_i) begin
        m_res   <= ref_op(int'(op_i), m_a, m_acc);
        cur_req <= force_r2 ? "R2" : req_of(int'(op_i));
      end else begin
        cur_req <= "R3";
      end
    end
  end

  task automatic check_out();
    checks++;
    if (int'(result_o) != m_res) begin
      errors++;
      $display("FAIL %s: result_o=%0d expected=%0d", cur_req, result_o, m_res);
    end
  endtask

  task automatic step(bit pa, bit pb, int op, int a, int acc);
    @(negedge clk_i);
    check_out();
    ph_a_i = pa; ph_b_i = pb;
    op_i = op[2:0]; a_i = a[3:0]; acc_i = acc[3:0];
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_out();  // R1 reset state
    rst_ni = 1'b1;

    // R2: operands change in idle cycles between the phases
    force_r2 = 1'b1;
    step(1, 0, 0, 5, 9);
    step(0, 0, 7, 15, 15);
    step(0, 0, 2, 3, 12);
    step(0, 1, 2, 0, 0);   // 9+5 = 14
    step(0, 0, 1, 1, 1);
    force_r2 = 1'b0;

    // all codes, all operand pairs; garbage on operands in phase B
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int acc = 0; acc < 16; acc++) begin
          step(1, 0, 7 - op, a, acc);
          step(0, 1, op, ~a, acc ^ 5);
        end
      end
    end

    // R3: phase A only, result must hold
    step(1, 0, 3, 7, 2);
    step(0, 0, 3, 1, 1);
    step(1, 0, 4, 8, 8);
    step(0, 0, 0, 0, 0);

    // R1: reset in mid-run
    step(0, 0, 0, 0, 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_out();
    rst_ni = 1'b1;
    step(0, 1, 2, 0, 0);
    step(0, 0, 0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule